// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external microprocessor treat an on-chip 8-bit register as a single latch on its own data bus. The external master uses active-low chip select, read and write strobes. These strobes are asynchronous to the block clock, so each one passes through a two-flop synchronizer before any edge is detected. The external data bus is split at the block boundary into an input, an output and an output enable, and the pad ring joins them into one bidirectional bus.

The internal side is a small synchronous register interface for the host CPU. Through it the CPU writes the outgoing latch, reads the incoming latch, sets the mode-enable bit, and watches the buffer flags and the sticky interrupt flag. The port responds to the external strobes only while the mode bit is set.

Top module: `par_slave_port`

## Requirements
- R1: After reset the mode bit, every status flag, `irq_o` and `ext_data_oe_o` are 0.
- R2: While the mode bit (CTRL address 1, bit 0) is clear, `ext_data_oe_o` stays 0 and the external strobes have no effect on the input latch or on any status flag.
- R3: An external write (chip select and write both low, mode set) captures the bus data into the input latch, which the CPU reads at address 0. The input-full flag (STATUS address 2, bit 0) is set on the third rising clock edge after the strobes are released.
- R4: `ext_data_oe_o` is 1 exactly while chip select and read are both low and the mode is set. During that time `ext_data_o` carries the output latch.
- R5: A CPU write to address 0 loads the output latch and sets the output-full flag (STATUS bit 1) on the next edge. The end of an external read clears that flag.
- R6: Each completed external read or write sets the interrupt flag (STATUS bit 3, mirrored on `irq_o`). The flag stays set until the CPU writes STATUS with bit 3 set to 1.
- R7: A CPU read of address 0 clears the input-full flag.
- R8: An external write that completes while input-full is set sets the overflow flag (STATUS bit 2), and the new data still replaces the input latch. Overflow stays set until the CPU writes STATUS with bit 2 set to 1.
- R9: A write is recognised once per low period of the strobes, however long that period lasts. No flag changes while the strobes are held low.
- R10: The mode bit reads back at CTRL bit 0 the cycle after the CPU writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_cs_ni | input | 1 | External chip select, active low |
| ext_rd_ni | input | 1 | External read strobe, active low |
| ext_wr_ni | input | 1 | External write strobe, active low |
| ext_data_i | input | 8 | External bus, incoming |
| ext_data_o | output | 8 | External bus, outgoing |
| ext_data_oe_o | output | 1 | External bus drive enable |
| cpu_we_i | input | 1 | CPU register write |
| cpu_re_i | input | 1 | CPU register read (side effects) |
| cpu_addr_i | input | 2 | CPU register address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, combinational from address |
| irq_o | output | 1 | Interrupt flag |

## Verification
Results that follow from external strobes pass two synchronizer flops and one edge-detect stage. A flag caused by a strobe release therefore appears on the third rising edge after the release. The bench releases the strobes at a falling edge and samples three falling edges later. CPU register writes and reads take effect on the next rising edge. The bus enable is a combinational function of the pins and the mode bit, so the bench checks it one time step after it drives the strobes. Every sample is taken at a falling edge, away from the rising edge at which the state changes.

// File: rtl/psp_pkg.sv
package psp_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_addr_e;

  localparam int unsigned STAT_IBF = 0;
  localparam int unsigned STAT_OBF = 1;
  localparam int unsigned STAT_OVF = 2;
  localparam int unsigned STAT_IRQ = 3;
  localparam int unsigned NUM_CH   = 2;  // channel 0 write, 1 read
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[s-1].q;
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/psp_strobe_det.sv
module psp_strobe_det
  import psp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_s_i,
  input  logic [NUM_CH-1:0] strobe_s_i,
  output logic [NUM_CH-1:0] act_o,
  output logic [NUM_CH-1:0] end_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cond, act, act_q, start;
    assign cond  = !cs_s_i && !strobe_s_i[c];
    assign act   = mode_i && cond;
    assign start = act && !act_q;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) act_q <= 1'b0;
      else         act_q <= act;

    assign act_o[c] = act;
    // end only counts if the mode held through the strobe
    assign end_o[c] = act_q && !cond && mode_i;

    assert_single_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |=> !start);
    assert_no_start_and_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(start && end_o[c]));
  end
endmodule

// File: rtl/psp_regs.sv
module psp_regs
  import psp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [DATA_W-1:0] ext_data_s_i,
  input  logic              wr_act_i,
  input  logic              wr_end_i,
  input  logic              rd_end_i,
  output logic              mode_o,
  output logic [DATA_W-1:0] out_latch_o,
  output logic              irq_o
);
  logic data_wr, data_rd, ctrl_wr, stat_wr;
  logic ibf_q, obf_q, ovf_q, irq_q, mode_q;
  logic irq_clr, ovf_clr, ovf_set;
  logic [DATA_W-1:0] in_hold_q, in_latch_q, out_latch_q;

  assign data_wr = cpu_we_i && (cpu_addr_i == REG_DATA);
  assign data_rd = cpu_re_i && (cpu_addr_i == REG_DATA);
  assign ctrl_wr = cpu_we_i && (cpu_addr_i == REG_CTRL);
  assign stat_wr = cpu_we_i && (cpu_addr_i == REG_STAT);
  assign irq_clr = stat_wr && cpu_wdata_i[STAT_IRQ];
  assign ovf_clr = stat_wr && cpu_wdata_i[STAT_OVF];
  assign ovf_set = wr_end_i && ibf_q && !data_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b0;
      ibf_q       <= 1'b0;
      obf_q       <= 1'b0;
      ovf_q       <= 1'b0;
      irq_q       <= 1'b0;
      in_hold_q   <= '0;
      in_latch_q  <= '0;
      out_latch_q <= '0;
    end else begin
      if (ctrl_wr) mode_q <= cpu_wdata_i[0];
      if (wr_act_i) in_hold_q <= ext_data_s_i;
      if (wr_end_i) in_latch_q <= in_hold_q;
      if (data_wr) out_latch_q <= cpu_wdata_i;

      if (wr_end_i)     ibf_q <= 1'b1;
      else if (data_rd) ibf_q <= 1'b0;

      if (data_wr)       obf_q <= 1'b1;
      else if (rd_end_i) obf_q <= 1'b0;

      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;

      if (wr_end_i || rd_end_i) irq_q <= 1'b1;
      else if (irq_clr)         irq_q <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    case (cpu_addr_i)
      REG_DATA: cpu_rdata_o = in_latch_q;
      REG_CTRL: cpu_rdata_o[0] = mode_q;
      REG_STAT: begin
        cpu_rdata_o[STAT_IBF] = ibf_q;
        cpu_rdata_o[STAT_OBF] = obf_q;
        cpu_rdata_o[STAT_OVF] = ovf_q;
        cpu_rdata_o[STAT_IRQ] = irq_q;
      end
      default: cpu_rdata_o = '0;
    endcase
  end

  assign mode_o      = mode_q;
  assign out_latch_o = out_latch_q;
  assign irq_o       = irq_q;

  assert_ibf_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end_i |=> ibf_q);
  assert_obf_on_cpu_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> obf_q);
  assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr) |=> irq_q);
  assert_ibf_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !wr_end_i) |=> !ibf_q);
  assert_ovf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_mode_readback_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (mode_q == $past(cpu_wdata_i[0])));
endmodule

// File: rtl/par_slave_port.sv
module par_slave_port
  import psp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_cs_ni,
  input  logic              ext_rd_ni,
  input  logic              ext_wr_ni,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              irq_o
);
  localparam int unsigned SYNC_W = DATA_W + 3;

  logic [SYNC_W-1:0] sync_d, sync_q;
  logic              cs_s;
  logic [NUM_CH-1:0] strobe_s, act, xfer_end;
  logic [DATA_W-1:0] data_s, out_latch;
  logic              mode;

  // data rides the same pipeline as the strobes to stay aligned
  assign sync_d = {ext_data_i, ext_cs_ni, ext_rd_ni, ext_wr_ni};

  psp_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({{DATA_W{1'b0}}, 3'b111})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign data_s   = sync_q[SYNC_W-1:3];
  assign cs_s     = sync_q[2];
  assign strobe_s = {sync_q[1], sync_q[0]};

  psp_strobe_det u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .cs_s_i    (cs_s),
    .strobe_s_i(strobe_s),
    .act_o     (act),
    .end_o     (xfer_end)
  );

  psp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_we_i    (cpu_we_i),
    .cpu_re_i    (cpu_re_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rdata_o (cpu_rdata_o),
    .ext_data_s_i(data_s),
    .wr_act_i    (act[0]),
    .wr_end_i    (xfer_end[0]),
    .rd_end_i    (xfer_end[1]),
    .mode_o      (mode),
    .out_latch_o (out_latch),
    .irq_o       (irq_o)
  );

  // drive is asynchronous to follow the master's read strobe directly
  assign ext_data_oe_o = mode && !ext_cs_ni && !ext_rd_ni;
  assign ext_data_o    = ext_data_oe_o ? out_latch : '0;

  assert_oe_needs_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> !ext_data_oe_o);
  assert_no_end_without_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> (xfer_end == '0));
endmodule

// File: tb/par_slave_port_test.sv
module par_slave_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ext_din = '0;
  logic [7:0] ext_dout;
  logic       oe;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_slave_port uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ext_cs_ni(cs_n), .ext_rd_ni(rd_n), .ext_wr_ni(wr_n),
    .ext_data_i(ext_din), .ext_data_o(ext_dout), .ext_data_oe_o(oe),
    .cpu_we_i(we), .cpu_re_i(re), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cpu_peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1; d = rdata;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    re = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic ext_write(input logic [7:0] d, input int hold);
    @(negedge clk);
    ext_din = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    cpu_peek(2'd2, v); chk("R1 status", v, 8'h00);
    cpu_peek(2'd1, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 oe", {7'd0, oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    ext_write(8'hA5, 4);
    cpu_peek(2'd2, v); chk("R2 status after write", v, 8'h00);
    cpu_peek(2'd0, v); chk("R2 latch untouched", v, 8'h00);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    chk("R2 oe while disabled", {7'd0, oe}, 8'h00);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cpu_peek(2'd2, v); chk("R2 status after read", v, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    cpu_wr(2'd1, 8'h01);
    cpu_peek(2'd1, v); chk("R10 mode readback", v, 8'h01);
  endtask

  task automatic t_write();
    logic [7:0] v;
    ext_write(8'h3C, 3);
    cpu_peek(2'd2, v); chk("R3 ibf and R6 irq", v, 8'h09);
    chk("R6 irq pin", {7'd0, irq}, 8'h01);
    cpu_rd(2'd0, v); chk("R3 captured data", v, 8'h3C);
    cpu_peek(2'd2, v); chk("R7 ibf cleared by read", v, 8'h08);
    cpu_wr(2'd2, 8'h08);
    cpu_peek(2'd2, v); chk("R6 irq cleared", v, 8'h00);
    chk("R6 irq pin low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    ext_write(8'h11, 2);
    ext_write(8'h22, 2);
    cpu_peek(2'd2, v); chk("R8 ovf set", v, 8'h0D);
    cpu_rd(2'd0, v); chk("R8 new data kept", v, 8'h22);
    cpu_peek(2'd2, v); chk("R8 ovf sticky", v, 8'h0C);
    cpu_wr(2'd2, 8'h04);
    cpu_peek(2'd2, v); chk("R8 ovf cleared", v, 8'h08);
    cpu_wr(2'd2, 8'h08);
  endtask

  task automatic t_read();
    logic [7:0] v;
    cpu_wr(2'd0, 8'h5A);
    cpu_peek(2'd2, v); chk("R5 obf set", v, 8'h02);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    chk("R4 oe during read", {7'd0, oe}, 8'h01);
    chk("R4 bus data", ext_dout, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R4 bus data held", ext_dout, 8'h5A);
    cs_n = 1'b1; rd_n = 1'b1; #1;
    chk("R4 oe released", {7'd0, oe}, 8'h00);
    repeat (3) @(negedge clk);
    cpu_peek(2'd2, v); chk("R5 obf cleared, R6 irq", v, 8'h08);
    cpu_wr(2'd2, 8'h08);
    @(negedge clk); cs_n = 1'b0; #1;
    chk("R4 no oe with cs only", {7'd0, oe}, 8'h00);
    cs_n = 1'b1;
  endtask

  task automatic t_once();
    logic [7:0] v;
    @(negedge clk);
    ext_din = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
    repeat (12) @(negedge clk);
    cpu_peek(2'd2, v); chk("R9 no flag during hold", v, 8'h00);
    repeat (10) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cpu_peek(2'd2, v); chk("R9 single event", v, 8'h09);
    cpu_rd(2'd0, v); chk("R9 data", v, 8'h77);
    cpu_wr(2'd2, 8'h08);
  endtask

  task automatic t_mode_off();
    logic [7:0] v;
    cpu_wr(2'd1, 8'h00);
    cpu_wr(2'd0, 8'h99);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    chk("R2 oe off after disable", {7'd0, oe}, 8'h00);
    repeat (2) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cpu_peek(2'd2, v); chk("R2 obf untouched", v, 8'h02);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_disabled();
    t_enable();
    t_write();
    t_overflow();
    t_read();
    t_once();
    t_mode_off();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule